// File: doc/BRIEF.md
# Fault Protection Supervisor

This block decides when a display set must be forced into a latched protection state. It watches three kinds of fault evidence. The first is a set of supply-rail dropout inputs. The second is a speaker DC-fault input. The third is the outcome of periodic acknowledge polls that an external I2C master sends to the tuner. Each kind has its own rule for when the evidence counts as a real fault.

A free-running timebase divides the clock into ticks. The tick period is a parameter, so a bench can shrink 100 ms down to a few clocks.

- **Supply rails.** A rail stays quiet until its dropout input rises. It then re-reads that input every 200 ms and emits a sample strobe each time. Five active readings in a row qualify the fault. One inactive reading sends the rail back to idle.
- **Tuner.** The block asks the I2C master for a tuner poll every 300 ms. The master reports each poll back as done and acknowledged or done and not acknowledged. Five missed acknowledges in a row qualify the fault, which keeps the tuner reaction time under 1.5 s.
- **Speaker DC fault.** This input acts at once and records no code.

The first qualified fault sets a sticky protection flag. It also stores an error code and a code-valid flag. Nothing but reset clears them.

Top module: `fault_guard`

## Requirements
- R1: While reset is asserted and directly after it, `prot`, `code_valid`, `err_code`, `rail_sample` and `poll_req` are all zero.
- R2: A rail issues no sample strobe until its dropout input shows a rising edge. After that edge it strobes `rail_sample[i]` once every SUP_TICKS ticks, where one tick is TICK_CYCLES clocks.
- R3: When a rail's input reads active on FAULT_COUNT consecutive sample strobes, protection is set on the next clock edge. `code_valid` becomes 1 and `err_code` takes that rail's byte of RAIL_CODES (bits 8i+7..8i; default 3 for rail 0 and 4 for rail 1).
- R4: A sample strobe that reads the rail input as inactive clears that rail's count and returns the rail to idle. The rail then needs a new rising edge before it strobes again.
- R5: `dc_fault` high for one cycle sets `prot` on the next edge, with `code_valid` = 0 and `err_code` = 0.
- R6: `poll_req` pulses for one cycle every POLL_TICKS ticks, from reset onward.
- R7: A cycle with `poll_done`=1 and `poll_ack`=0 counts one missed poll. A cycle with `poll_done`=1 and `poll_ack`=1 clears the count. On the FAULT_COUNT-th consecutive miss, protection is set with `code_valid`=1 and `err_code`=13.
- R8: Once `prot` is set, it and `code_valid` and `err_code` hold until reset, whatever faults follow.
- R9: When several faults qualify in the same cycle, the winner is chosen in this order: DC fault first, then rail 0, then the higher rail indices in order, then the tuner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| rail_fault | input | NUM_RAILS | Supply dropout inputs, one per rail, synchronous |
| dc_fault | input | 1 | Speaker DC fault, acts immediately |
| poll_done | input | 1 | Tuner poll result strobe from the I2C master |
| poll_ack | input | 1 | Tuner acknowledged, valid with poll_done |
| rail_sample | output | NUM_RAILS | One-cycle strobe when a rail input is being sampled |
| poll_req | output | 1 | One-cycle request for a tuner poll |
| prot | output | 1 | Latched protection flag |
| code_valid | output | 1 | Stored error code is meaningful |
| err_code | output | 8 | First stored error code |

## Verification
Three things can meet in one cycle: the fifth active rail sample, the fifth missed tuner poll and a DC fault. The bench first drives the tuner count to four misses. It then waits for the fourth active strobe on both rails and counts forward to the next strobe cycle. In that cycle it pulses a missed poll, and in one run it also pulses the DC input. The expected result is rail 0's code when only the rails and the tuner coincide. When the DC input joins them, the expected result is protection with no valid code. A behavioural model runs alongside the design and judges every output on every clock.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t TUNER_CODE = 8'd13;

    typedef struct packed {
        logic  prot;
        logic  valid;
        code_t code;
    } latch_t;
endpackage

// File: rtl/fg_timebase.sv
module fg_timebase #(
    parameter int TICK_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = $clog2(TICK_CYCLES) + 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fg_rail_qual.sv
module fg_rail_qual #(
    parameter int SUP_TICKS   = 2,
    parameter int FAULT_COUNT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fault_in,
    output logic sample,
    output logic qualified
);
    localparam int SW = $clog2(SUP_TICKS) + 1;
    localparam int CW = $clog2(FAULT_COUNT) + 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(SUP_TICKS - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FAULT_COUNT - 1);

    typedef struct packed {
        logic          active;
        logic          prev;
        logic [SW-1:0] sub;
        logic [CW-1:0] cnt;
    } rail_st_t;

    rail_st_t s_d, s_q;
    logic     edge_seen;

    always_comb begin
        s_d       = s_q;
        edge_seen = fault_in & ~s_q.prev;
        sample    = s_q.active & tick & (s_q.sub == SUB_LAST);
        qualified = sample & fault_in & (s_q.cnt == CNT_LAST);
        s_d.prev  = fault_in;
        if (!s_q.active) begin
            if (edge_seen) begin
                s_d.active = 1'b1;
                s_d.sub    = '0;
                s_d.cnt    = '0;
            end
        end else if (tick) begin
            if (sample) begin
                s_d.sub = '0;
                if (!fault_in || qualified) begin
                    s_d.active = 1'b0;
                    s_d.cnt    = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    a_r4_inactive_sample_idles: assert property (@(posedge clk) disable iff (rst)
        (sample && !fault_in) |=> (!s_q.active && s_q.cnt == '0));

    a_r2_idle_without_edge: assert property (@(posedge clk) disable iff (rst)
        (!s_q.active && !fault_in) |=> !sample);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CNT_LAST);
endmodule

// File: rtl/fg_tuner_qual.sv
module fg_tuner_qual #(
    parameter int POLL_TICKS  = 3,
    parameter int FAULT_COUNT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic poll_done,
    input  logic poll_ack,
    output logic poll_req,
    output logic qualified
);
    localparam int PW = $clog2(POLL_TICKS) + 1;
    localparam int CW = $clog2(FAULT_COUNT) + 1;
    localparam logic [PW-1:0] P_LAST   = PW'(POLL_TICKS - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FAULT_COUNT - 1);

    typedef struct packed {
        logic [PW-1:0] psub;
        logic [CW-1:0] cnt;
    } tun_st_t;

    tun_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        poll_req  = tick & (s_q.psub == P_LAST);
        qualified = poll_done & ~poll_ack & (s_q.cnt == CNT_LAST);
        if (tick) s_d.psub = poll_req ? '0 : s_q.psub + 1'b1;
        if (poll_done) begin
            if (poll_ack || qualified) s_d.cnt = '0;
            else                       s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (poll_done && poll_ack) |=> (s_q.cnt == '0));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CNT_LAST);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
    import fg_pkg::*;
#(
    parameter int                      NUM_RAILS   = 2,
    parameter int                      TICK_CYCLES = 5_000_000,
    parameter int                      SUP_TICKS   = 2,
    parameter int                      POLL_TICKS  = 3,
    parameter int                      FAULT_COUNT = 5,
    parameter logic [NUM_RAILS*8-1:0]  RAIL_CODES  = {8'd4, 8'd3}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] rail_fault,
    input  logic                 dc_fault,
    input  logic                 poll_done,
    input  logic                 poll_ack,
    output logic [NUM_RAILS-1:0] rail_sample,
    output logic                 poll_req,
    output logic                 prot,
    output logic                 code_valid,
    output logic [CODE_W-1:0]    err_code
);
    logic                 tick;
    logic [NUM_RAILS-1:0] rail_qual;
    logic                 tuner_qual;
    logic                 any_rail;
    code_t                rail_code;
    latch_t               l_d, l_q;

    fg_timebase #(.TICK_CYCLES(TICK_CYCLES)) u_tb (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        fg_rail_qual #(.SUP_TICKS(SUP_TICKS), .FAULT_COUNT(FAULT_COUNT)) u_rail (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .fault_in (rail_fault[g]),
            .sample   (rail_sample[g]),
            .qualified(rail_qual[g])
        );
    end

    fg_tuner_qual #(.POLL_TICKS(POLL_TICKS), .FAULT_COUNT(FAULT_COUNT)) u_tuner (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .poll_done(poll_done),
        .poll_ack (poll_ack),
        .poll_req (poll_req),
        .qualified(tuner_qual)
    );

    always_comb begin
        any_rail  = 1'b0;
        rail_code = '0;
        for (int i = NUM_RAILS - 1; i >= 0; i--) begin
            if (rail_qual[i]) begin
                any_rail  = 1'b1;
                rail_code = RAIL_CODES[i*8 +: 8];
            end
        end
        l_d = l_q;
        if (!l_q.prot) begin
            if (dc_fault) begin
                l_d = '{prot: 1'b1, valid: 1'b0, code: '0};
            end else if (any_rail) begin
                l_d = '{prot: 1'b1, valid: 1'b1, code: rail_code};
            end else if (tuner_qual) begin
                l_d = '{prot: 1'b1, valid: 1'b1, code: TUNER_CODE};
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) l_q <= '0;
        else     l_q <= l_d;
    end

    assign prot       = l_q.prot;
    assign code_valid = l_q.valid;
    assign err_code   = l_q.code;

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        l_q.prot |=> l_q.prot);

    a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
        l_q.prot |=> ($stable(l_q.code) && $stable(l_q.valid)));

    a_r5_dc_immediate: assert property (@(posedge clk) disable iff (rst)
        (dc_fault && !l_q.prot) |=> (l_q.prot && !l_q.valid && l_q.code == '0));

    a_r9_dc_beats_rest: assert property (@(posedge clk) disable iff (rst)
        (dc_fault && !l_q.prot && (tuner_qual || (|rail_qual))) |=> !l_q.valid);

    a_r7_tuner_code: assert property (@(posedge clk) disable iff (rst)
        (tuner_qual && !l_q.prot && !dc_fault && !(|rail_qual))
            |=> (l_q.valid && l_q.code == TUNER_CODE));

    a_r3_valid_needs_prot: assert property (@(posedge clk) disable iff (rst)
        l_q.valid |-> l_q.prot);
endmodule

// File: tb/fault_guard_test.sv
module fault_guard_test;
    localparam int TC = 4;
    localparam int ST = 2;
    localparam int PT = 3;
    localparam int FC = 5;
    localparam int NR = 2;
    localparam logic [15:0] CODES = {8'd4, 8'd3};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic [NR-1:0] rail = '0;
    logic          dc = 1'b0, pd = 1'b0, pa = 1'b0;
    logic [NR-1:0] rail_sample;
    logic          poll_req, prot, code_valid;
    logic [7:0]    err_code;

    fault_guard #(
        .NUM_RAILS(NR), .TICK_CYCLES(TC), .SUP_TICKS(ST),
        .POLL_TICKS(PT), .FAULT_COUNT(FC), .RAIL_CODES(CODES)
    ) uut (
        .clk(clk), .rst(rst), .rail_fault(rail), .dc_fault(dc),
        .poll_done(pd), .poll_ack(pa), .rail_sample(rail_sample),
        .poll_req(poll_req), .prot(prot), .code_valid(code_valid),
        .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;
    int poll_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_tcnt, m_psub, m_tun;
    int m_act[NR], m_sub[NR], m_cnt[NR];
    bit m_prev[NR];
    bit m_prot, m_valid;
    int m_code;

    always @(negedge clk) begin
        bit tick, e_poll, q_t, hit;
        bit e_samp[NR], q_r[NR];
        int hcode;
        if (rst) begin
            m_tcnt = 0; m_psub = 0; m_tun = 0;
            m_prot = 0; m_valid = 0; m_code = 0;
            for (int i = 0; i < NR; i++) begin
                m_act[i] = 0; m_sub[i] = 0; m_cnt[i] = 0; m_prev[i] = 0;
            end
            chk(prot == 0 && code_valid == 0 && err_code == 0, "R1 reset outputs", int'(prot), 0);
            chk(rail_sample == 0 && poll_req == 0, "R1 reset strobes", int'(rail_sample), 0);
        end else begin
            tick   = (m_tcnt == TC - 1);
            e_poll = tick && (m_psub == PT - 1);
            for (int i = 0; i < NR; i++) begin
                e_samp[i] = (m_act[i] != 0) && tick && (m_sub[i] == ST - 1);
                q_r[i]    = e_samp[i] && rail[i] && (m_cnt[i] == FC - 1);
            end
            q_t = pd && !pa && (m_tun == FC - 1);
            for (int i = 0; i < NR; i++)
                chk(rail_sample[i] == e_samp[i], "R2 rail sample strobe", int'(rail_sample[i]), int'(e_samp[i]));
            chk(poll_req == e_poll, "R6 poll request", int'(poll_req), int'(e_poll));
            chk(prot == m_prot, "R8 protection flag", int'(prot), int'(m_prot));
            chk(code_valid == m_valid, "R9 code valid", int'(code_valid), int'(m_valid));
            chk(int'(err_code) == m_code, "R9 error code", int'(err_code), m_code);
            if (poll_req) poll_seen++;
            // advance
            if (e_poll) m_psub = 0; else if (tick) m_psub++;
            m_tcnt = tick ? 0 : m_tcnt + 1;
            for (int i = 0; i < NR; i++) begin
                if (m_act[i] == 0) begin
                    if (rail[i] && !m_prev[i]) begin
                        m_act[i] = 1; m_sub[i] = 0; m_cnt[i] = 0;
                    end
                end else if (tick) begin
                    if (m_sub[i] == ST - 1) begin
                        m_sub[i] = 0;
                        if (!rail[i] || m_cnt[i] == FC - 1) begin
                            m_act[i] = 0; m_cnt[i] = 0;
                        end else m_cnt[i]++;
                    end else m_sub[i]++;
                end
                m_prev[i] = rail[i];
            end
            if (pd) begin
                if (pa || m_tun == FC - 1) m_tun = 0; else m_tun++;
            end
            hit = 0; hcode = 0;
            for (int i = NR - 1; i >= 0; i--)
                if (q_r[i]) begin hit = 1; hcode = int'(CODES[i*8 +: 8]); end
            if (!m_prot) begin
                if (dc) begin m_prot = 1; m_valid = 0; m_code = 0; end
                else if (hit) begin m_prot = 1; m_valid = 1; m_code = hcode; end
                else if (q_t) begin m_prot = 1; m_valid = 1; m_code = 13; end
            end
        end
    end

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; rail = '0; dc = 0; pd = 0; pa = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic poll_result(input bit ack);
        pd = 1; pa = ack;
        @(posedge clk); #1;
        pd = 0; pa = 0;
        cycles(1);
    endtask

    task automatic wait_samples(input int idx, input int n);
        repeat (n) begin
            do @(negedge clk); while (!rail_sample[idx]);
        end
    endtask

    initial begin
        int p0;
        do_reset();
        // R6: polls every 12 clocks; R2: no strobes without an edge
        p0 = poll_seen;
        cycles(36);
        chk(poll_seen - p0 == 3, "R6 poll count", poll_seen - p0, 3);
        chk(rail_sample == 0 && prot == 0, "R2 idle rails quiet", int'(prot), 0);

        // R3: rail 0 five active samples
        rail[0] = 1;
        wait_samples(0, 5);
        cycles(1);
        @(negedge clk);
        chk(prot && code_valid && err_code == 8'd3, "R3 rail0 code", int'(err_code), 3);

        // R4: break in the run on rail 1
        do_reset();
        rail[1] = 1;
        wait_samples(1, 3);
        @(posedge clk); #1 rail[1] = 0;
        wait_samples(1, 1);
        cycles(30);
        chk(prot == 0, "R4 broken run no protection", int'(prot), 0);
        rail[1] = 1;
        wait_samples(1, 4);
        cycles(2);
        chk(prot == 0, "R4 restart count from zero", int'(prot), 0);
        wait_samples(1, 1);
        cycles(1);
        chk(prot && err_code == 8'd4, "R3 rail1 code", int'(err_code), 4);

        // R5 and R8: DC fault, later rail fault keeps first result
        do_reset();
        cycles(3);
        dc = 1; cycles(1); dc = 0;
        chk(prot && !code_valid && err_code == 0, "R5 dc fault", int'(prot), 1);
        rail[0] = 1;
        cycles(60);
        chk(prot && !code_valid && err_code == 0, "R8 first result kept", int'(err_code), 0);

        // R7: tuner misses with an ack in between
        do_reset();
        repeat (4) poll_result(0);
        poll_result(1);
        repeat (4) poll_result(0);
        chk(prot == 0, "R7 ack clears miss count", int'(prot), 0);
        poll_result(0);
        chk(prot && code_valid && err_code == 8'd13, "R7 tuner code", int'(err_code), 13);
        repeat (5) poll_result(0);
        chk(err_code == 8'd13, "R8 code held", int'(err_code), 13);

        // R9: both rails and tuner qualify in one cycle
        do_reset();
        repeat (4) poll_result(0);
        rail = 2'b11;
        wait_samples(0, 4);
        repeat (8) @(posedge clk);
        #1 pd = 1; pa = 0;
        cycles(1);
        pd = 0;
        chk(prot && code_valid && err_code == 8'd3, "R9 rail0 wins", int'(err_code), 3);

        // R9: DC joins the same cycle
        do_reset();
        repeat (4) poll_result(0);
        rail = 2'b11;
        wait_samples(0, 4);
        repeat (8) @(posedge clk);
        #1 pd = 1; pa = 0; dc = 1;
        cycles(1);
        pd = 0; dc = 0;
        chk(prot && !code_valid && err_code == 0, "R9 dc wins", int'(err_code), 0);
        cycles(5);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end
endmodule